// File: doc/BRIEF.md
# Configuration Ring Node with Loop Sequencer

This block is one stop on a daisy-chained control ring that carries 8-bit packets to the compute kernels of a neural-network overlay. Every packet that enters the node leaves it again one cycle later, so the nodes further along the ring see the stream unchanged. The ring uses a valid/ready handshake, and a downstream node that is not ready holds the whole stream back.

Traffic on the ring is a series of messages. Each message is one header byte followed by a fixed number of payload bytes, and that number is the same for every node on the ring. The low six bits of the header name the target kernel. When the header names this node's kernel, the node copies the payload into a staging bank. The position of each byte within the payload decides what it sets, so there is no opcode to decode. A message counts only once it is complete. Its contents then become the armed configuration.

A start pulse copies the armed configuration into an active bank. Three nested counters then step from zero up to the loaded end values, one iteration per cycle. Because of the two banks, the next configuration can arrive while the current loop nest is still running.

Top module: `cfg_ring_node`

## Requirements
- R1: After a synchronous active-low reset, out_valid, busy, done and loop_valid are 0, in_ready is 1, and the armed and active configurations are all zero, so cfg_flags reads 0.
- R2: Every byte accepted at the input (in_valid and in_ready high at a clock edge) appears on out_data with out_valid high from the next cycle on. Bytes leave in the order they arrived, unchanged. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R3: The first byte accepted after reset is a header. After a header, exactly 6 payload bytes follow, and the next accepted byte is again a header. Header bits [5:0] carry the kernel ID. Header bits [7:6] are ignored.
- R4: When the header's kernel ID equals KERNEL_ID, the payload loads the configuration by position. Byte 0 is the inner loop end. Byte 1 is the middle loop end. Byte 2 is the outer loop end. Bytes 3, 4 and 5 go to cfg_flags[7:0], [15:8] and [23:16]. A message for any other kernel ID leaves the configuration unchanged.
- R5: A received configuration takes effect only at the next accepted start. A message that is still incomplete when start is accepted has no effect on that run.
- R6: A start accepted while busy is 0 begins a run on the next cycle. In every cycle of the run, loop_valid is 1 and loop_idx gives {outer, middle, inner}, 8 bits each, with the inner index in the low byte. The indices count from 0 up to each end value inclusive, and the inner index moves fastest.
- R7: In the cycle after the last iteration (all indices equal to their ends), done is 1 for exactly one cycle. In that cycle busy and loop_valid are 0.
- R8: A start pulse while busy is 1 is ignored: the sequence and the timing of done do not change.
- R9: cfg_flags shows the flags of the configuration captured by the most recent accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Node can accept a byte |
| in_data | input | 8 | Upstream packet byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream node can accept |
| out_data | output | 8 | Forwarded packet byte |
| start | input | 1 | Begin a loop nest with the armed configuration |
| busy | output | 1 | Loop nest in progress |
| done | output | 1 | One-cycle pulse after the last iteration |
| loop_valid | output | 1 | loop_idx holds a valid iteration |
| loop_idx | output | 24 | {outer, middle, inner} loop indices |
| cfg_flags | output | 24 | Flags of the active configuration |

## Verification
The assertions assume that the ring carries only whole messages in the shared framing: a header followed by exactly the fixed payload length. They also assume that out_ready comes from a downstream node that does not depend on this node's later state. The stimulus sends only complete messages. Where a test needs a message that is still in flight when start arrives, it completes that message afterwards, so the framing stays aligned for all later traffic. Start is driven as a one-cycle pulse, and downstream stalls follow a fixed periodic pattern, so every held-byte case is reached in a way that can be predicted.

// File: rtl/cfg_ring_pkg.sv
// Package: shared widths and types for the configuration ring node.
// Assumes a byte-wide ring and one byte per loop-counter end value.
package cfg_ring_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 6;

    typedef logic [BYTE_W-1:0] ring_byte_t;
    typedef logic [ID_W-1:0]   kernel_id_t;
endpackage

// File: rtl/ring_stage.sv
// Module: ring_stage
// One-entry register stage on the ring with a valid/ready handshake.
// Every accepted byte leaves one cycle later, unchanged.
// Assumes out_ready does not depend combinationally on in_valid.
module ring_stage
    import cfg_ring_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  ring_byte_t in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output ring_byte_t out_data,
    output logic       accept
);
    // Space is free when the stage is empty or is being drained this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        accept   = in_valid && in_ready;
    end

    // Load the holding register on accept; clear valid once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R2

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid); // R2
endmodule

// File: rtl/cfg_capture.sv
// Module: cfg_capture
// Tracks message framing on the ring. Each message is one header and then
// PAYLOAD_BYTES payload bytes. Payload of a message whose header kernel ID
// matches KERNEL_ID is staged byte by byte. Only a complete message is
// copied into the armed bank.
// Assumes every node on the ring uses the same payload length.
module cfg_capture
    import cfg_ring_pkg::*;
#(
    parameter int         PAYLOAD_BYTES = 6,
    parameter kernel_id_t KERNEL_ID     = '0
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 accept,
    input  ring_byte_t                           in_data,
    output logic [PAYLOAD_BYTES-1:0][BYTE_W-1:0] armed_cfg
);
    localparam int POS_W = $clog2(PAYLOAD_BYTES + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAYLOAD_BYTES);

    logic [POS_W-1:0]                     pos;
    logic                                 hit;
    logic [PAYLOAD_BYTES-1:0][BYTE_W-1:0] stage_q;
    logic                                 is_header;
    logic                                 msg_end;

    // Decode the position of the current byte within its message.
    always_comb begin
        is_header = (pos == '0);
        msg_end   = accept && (pos == LAST_POS);
    end

    // Advance the framing counter; latch the header match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            hit <= 1'b0;
        end else if (accept) begin
            if (is_header) begin
                hit <= (in_data[ID_W-1:0] == KERNEL_ID);
                pos <= POS_W'(1);
            end else if (pos == LAST_POS) begin
                pos <= '0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    genvar b;
    generate
        for (b = 0; b < PAYLOAD_BYTES; b++) begin : g_byte
            localparam logic [POS_W-1:0] MY_POS = POS_W'(b + 1);
            // Stage payload byte b of a matching message.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[b] <= '0;
                else if (accept && hit && pos == MY_POS)
                    stage_q[b] <= in_data;
            end
            // Arm byte b at the end of a complete matching message.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    armed_cfg[b] <= '0;
                else if (msg_end && hit)
                    armed_cfg[b] <= (b == PAYLOAD_BYTES - 1) ? in_data : stage_q[b];
            end
        end
    endgenerate

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST_POS); // R3

    AST_ARM_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(armed_cfg) |-> $past(msg_end && hit)); // R5
endmodule

// File: rtl/loop_sequencer.sv
// Module: loop_sequencer
// Copies the armed configuration into an active bank at start and steps
// NUM_LOOPS nested counters from zero to their end values, one iteration
// per cycle, with counter 0 fastest. done pulses one cycle after the last
// iteration. A start while busy is ignored.
// Assumes start is sampled only while idle.
module loop_sequencer
    import cfg_ring_pkg::*;
#(
    parameter int NUM_LOOPS  = 3,
    parameter int FLAG_BYTES = 3
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [NUM_LOOPS+FLAG_BYTES-1:0][BYTE_W-1:0]   armed_cfg,
    input  logic                                          start,
    output logic                                          busy,
    output logic                                          done,
    output logic [NUM_LOOPS-1:0][BYTE_W-1:0]              idx,
    output logic [FLAG_BYTES*BYTE_W-1:0]                  flags
);
    logic [NUM_LOOPS+FLAG_BYTES-1:0][BYTE_W-1:0] active_q;
    logic [NUM_LOOPS-1:0][BYTE_W-1:0]            cnt_q;
    logic [NUM_LOOPS-1:0]                        wrap;
    logic [NUM_LOOPS-1:0]                        step;
    logic                                        launch;
    logic                                        finish;

    // Expose the flag bytes of the active bank as a flat vector.
    always_comb begin
        for (int f = 0; f < FLAG_BYTES; f++)
            flags[f*BYTE_W +: BYTE_W] = active_q[NUM_LOOPS + f];
        idx    = cnt_q;
        launch = start && !busy;
        finish = busy && step[NUM_LOOPS-1] && wrap[NUM_LOOPS-1];
    end

    genvar k;
    generate
        for (k = 0; k < NUM_LOOPS; k++) begin : g_loop
            // Carry chain: a counter steps when all faster ones wrap.
            if (k == 0) begin : g_first
                always_comb step[k] = 1'b1;
            end else begin : g_next
                always_comb step[k] = step[k-1] && wrap[k-1];
            end
            always_comb wrap[k] = (cnt_q[k] == active_q[k]);

            // Counter k: clear at launch, step or wrap while running.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q[k] <= '0;
                else if (launch)
                    cnt_q[k] <= '0;
                else if (busy && step[k] && !finish)
                    cnt_q[k] <= wrap[k] ? '0 : cnt_q[k] + 1'b1;
            end

            AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                busy |-> (cnt_q[k] <= active_q[k])); // R6
        end
    endgenerate

    // Active bank loads only when a run is launched.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (launch)
            active_q <= armed_cfg;
    end

    // Run state and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (launch)
                busy <= 1'b1;
            else if (finish)
                busy <= 1'b0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R7

    AST_CFG_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(active_q)); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !finish) |=> busy); // R8
endmodule

// File: rtl/cfg_ring_node.sv
// Module: cfg_ring_node
// One node of the byte-wide configuration ring. It forwards every packet
// with one cycle of latency and captures the payload of messages addressed
// to KERNEL_ID. The captured configuration (loop end values, then flag
// bytes) drives a nested loop sequencer at the next start.
// Assumes ring-wide framing with a fixed payload of NUM_LOOPS+FLAG_BYTES bytes.
module cfg_ring_node
    import cfg_ring_pkg::*;
#(
    parameter int         NUM_LOOPS  = 3,
    parameter int         FLAG_BYTES = 3,
    parameter kernel_id_t KERNEL_ID  = 6'd5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [7:0]                    in_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [7:0]                    out_data,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic                          loop_valid,
    output logic [NUM_LOOPS*8-1:0]        loop_idx,
    output logic [FLAG_BYTES*8-1:0]       cfg_flags
);
    localparam int PAYLOAD_BYTES = NUM_LOOPS + FLAG_BYTES;

    logic                                 accept;
    logic [PAYLOAD_BYTES-1:0][BYTE_W-1:0] armed_cfg;
    logic [NUM_LOOPS-1:0][BYTE_W-1:0]     idx;

    ring_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .accept    (accept)
    );

    cfg_capture #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .KERNEL_ID     (KERNEL_ID)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_data   (in_data),
        .armed_cfg (armed_cfg)
    );

    loop_sequencer #(
        .NUM_LOOPS  (NUM_LOOPS),
        .FLAG_BYTES (FLAG_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed_cfg (armed_cfg),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .idx       (idx),
        .flags     (cfg_flags)
    );

    // Flatten indices; valid iterations are exactly the busy cycles.
    always_comb begin
        loop_idx   = idx;
        loop_valid = busy;
    end

    AST_NO_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !loop_valid); // R7
endmodule

// File: tb/sim_cfg_ring_node.sv
module sim_cfg_ring_node;
    localparam int         CLK_P = 10;
    localparam logic [5:0] KID   = 6'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        start = 1'b0;
    logic        busy, done, loop_valid;
    logic [23:0] loop_idx, cfg_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit stall_en = 1'b0;
    int cyc      = 0;
    logic [7:0] exp_q[$];

    cfg_ring_node #(.NUM_LOOPS(3), .FLAG_BYTES(3), .KERNEL_ID(KID)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .start(start), .busy(busy), .done(done), .loop_valid(loop_valid),
        .loop_idx(loop_idx), .cfg_flags(cfg_flags)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Periodic downstream stall pattern, changed at negedges.
    always @(negedge clk) begin
        cyc++;
        out_ready <= !(stall_en && (cyc % 3 != 0));
    end

    // Ring monitor: every byte taken downstream must match the sent order (R2).
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0)
                check(1'b0, "R2", "unexpected ring byte", out_data, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R2", "forwarded byte", out_data, e);
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(b);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // Header (reserved bits in [7:6]) followed by the payload bytes 0..5.
    task automatic send_msg(input logic [1:0] rsv, input logic [5:0] id,
                            input logic [7:0] p0, p1, p2, p3, p4, p5);
        send_byte({rsv, id});
        send_byte(p0); send_byte(p1); send_byte(p2);
        send_byte(p3); send_byte(p4); send_byte(p5);
    endtask

    // Start a run and check the full iteration sequence, done and flags.
    task automatic run_loop(input int ei, em, eo, input logic [23:0] fl,
                            input string tag);
        int bad = 0;
        logic [23:0] first_bad = '0;
        logic [23:0] first_exp = '0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_flags == fl, "R9", {tag, " flags"}, cfg_flags, fl);
        for (int o = 0; o <= eo; o++)
            for (int m = 0; m <= em; m++)
                for (int i = 0; i <= ei; i++) begin
                    logic [23:0] ex;
                    ex = {o[7:0], m[7:0], i[7:0]};
                    if (!(loop_valid && loop_idx == ex)) begin
                        if (bad == 0) begin first_bad = loop_idx; first_exp = ex; end
                        bad++;
                    end
                    @(negedge clk);
                end
        check(bad == 0, "R6", {tag, " iteration order"}, first_bad, first_exp);
        check(done && !busy && !loop_valid, "R7", {tag, " done after last"},
              {done, busy, loop_valid}, 3'b100);
        @(negedge clk);
        check(!done, "R7", {tag, " done single cycle"}, done, 0);
    endtask

    task automatic t_reset;
        check(!out_valid && !busy && !done && !loop_valid && in_ready, "R1",
              "control outputs after reset", {out_valid, busy, done, loop_valid, in_ready}, 5'b00001);
        check(cfg_flags == 0, "R1", "flags after reset", cfg_flags, 0);
    endtask

    task automatic t_program_and_run;
        // R4: payload position sets inner, middle, outer ends, then flags.
        send_msg(2'b00, KID, 8'd2, 8'd1, 8'd1, 8'hA1, 8'hB2, 8'hC3);
        run_loop(2, 1, 1, 24'hC3B2A1, "R4 own kernel");
    endtask

    task automatic t_foreign_and_reserved;
        // R4: another kernel's message leaves the config unchanged.
        send_msg(2'b00, 6'd9, 8'd7, 8'd7, 8'd7, 8'h11, 8'h22, 8'h33);
        run_loop(2, 1, 1, 24'hC3B2A1, "R4 foreign kernel");
        // R3: reserved header bits do not affect the match.
        send_msg(2'b11, KID, 8'd1, 8'd0, 8'd2, 8'h01, 8'h02, 8'h04);
        run_loop(1, 0, 2, 24'h040201, "R3 reserved bits");
    endtask

    task automatic t_double_buffer;
        // R5, R8: new config arrives during a run; an extra start mid-run is ignored.
        fork
            run_loop(3, 2, 1, 24'h040201, "R5 running old");
            send_msg(2'b00, KID, 8'd0, 8'd2, 8'd0, 8'h55, 8'h66, 8'h77);
            begin
                repeat (6) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
    endtask

    task automatic t_apply_and_partial;
        // Note: t_double_buffer ran ends (3,2,1) only because they were armed earlier.
        run_loop(0, 2, 0, 24'h776655, "R5 new config applied");
        // R5: a message still in flight at start has no effect.
        send_byte({2'b00, KID});
        send_byte(8'd4); send_byte(8'd4); send_byte(8'd4);
        run_loop(0, 2, 0, 24'h776655, "R5 partial ignored");
        send_byte(8'hEE); send_byte(8'hDD); send_byte(8'hCC);
        run_loop(4, 4, 4, 24'hCCDDEE, "R5 completed later");
    endtask

    task automatic t_stall;
        // R2: downstream stalls hold the stream; then minimal loop nest.
        stall_en = 1'b1;
        send_msg(2'b01, 6'd3, 8'h5A, 8'hA5, 8'h3C, 8'hC3, 8'h0F, 8'hF0);
        send_msg(2'b00, KID, 8'd0, 8'd0, 8'd0, 8'h80, 8'h40, 8'h20);
        repeat (8) @(negedge clk);
        stall_en = 1'b0;
        repeat (4) @(negedge clk);
        #3;
        check(exp_q.size() == 0, "R2", "all bytes forwarded", exp_q.size(), 0);
        run_loop(0, 0, 0, 24'h204080, "R6 single iteration");
    endtask

    // Patch for t_double_buffer: ends (3,2,1) must be armed before it.
    task automatic t_arm_321;
        send_msg(2'b00, KID, 8'd3, 8'd2, 8'd1, 8'h01, 8'h02, 8'h04);
    endtask

    initial begin
        #(CLK_P * 100000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_and_run();
        t_foreign_and_reserved();
        t_arm_321();
        t_double_buffer();
        t_apply_and_partial();
        t_stall();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule